// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

This block collects eight interrupt request lines, resolves them by fixed priority with line 0 the most urgent, and signals the host through one interrupt output. When the host acknowledges, it returns an 8-bit vector. Software reaches it through two byte addresses. The command address starts initialization and takes end-of-interrupt commands. The data address takes the initialization words and, once the block is configured, the mask register.

Two instances can be chained. The role of each instance is set by a pin. The master learns from its cascade word which of its lines carry a subordinate controller. A subordinate learns its own identity number from the same word. When the host acknowledges a line that carries a subordinate, the master puts that line number on the cascade bus and strobes it. The subordinate whose identity matches then takes the acknowledge and supplies the vector. Requests from a subordinate reach the host only through the master's line, so the master's mask for that line gates them.

Top module: `irq_ctrl`

## Requirements
- R1: A command write with bit 4 set begins configuration. The following data writes are taken in this order: the vector base; then the cascade word, unless command bit 1 (single) was set; then the mode word, only if command bit 0 was set. Only after that do data writes load the mask. While configuration is in progress `irq_out` stays low.
- R2: After reset the mask reads 0xFF, and `irq_out` and `vec_valid` are low. The first configuration write clears the mask to 0x00 and empties the request and in-service sets.
- R3: On an acknowledge, `vec_out` holds {base word bits 7:3, 3-bit line number} and `vec_valid` is high during the cycle after the acknowledging edge. For example, base 0x20 with line 5 gives 0x25.
- R4: A mask bit of 1 blocks its line and a 0 enables it. A data read returns the mask. A command read returns the request register, with bit n for line n.
- R5: `irq_out` is high exactly when an enabled pending request has a lower line number than every in-service line. Line 0 has the highest priority.
- R6: An acknowledge moves the winning request into the in-service set and clears its latched request.
- R7: Writing 0x20 to the command address clears the lowest-numbered in-service bit. Only that one bit is cleared.
- R8: Command bit 3 selects level inputs, where a request follows its pin. Otherwise a rising edge latches the request until it is acknowledged. A master's cascade lines always follow their pin.
- R9: Mode word bit 1 selects automatic end-of-interrupt: an acknowledge then leaves the in-service set unchanged.
- R10: When a master acknowledges a cascade line, it strobes `cas_strobe` with the line number on `cas_out` and leaves `vec_valid` low. The subordinate whose identity (cascade word bits 2:0) matches `cas_in` supplies the vector.
- R11: A request from a subordinate does not reach the host while the master masks the cascade line, even though the subordinate's own `irq_out` is high.
- R12: An acknowledge that arrives with no winning request returns {base, 7} and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1 selects the master role, 0 the subordinate role |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command address, 1 the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Mask when reg_sel is 1, request register when it is 0 |
| irq_in | input | 8 | Request lines |
| irq_out | output | 1 | Interrupt to the host or to the master |
| ack_in | input | 1 | One-cycle acknowledge (host for a master, master cas_strobe for a subordinate) |
| cas_in | input | 3 | Cascade line number seen by a subordinate |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_strobe | output | 1 | Master passes the acknowledge down the cascade |
| vec_out | output | 8 | Vector |
| vec_valid | output | 1 | Vector is valid this cycle |

## Verification
A rising request edge is registered on the next clock, and `irq_out` follows combinationally from that register. It is therefore due one edge after the pin rises and is sampled just after the following falling edge. In level mode, and on cascade lines, the request follows the pin with no register, so `irq_out` changes in the same cycle as its input. The vector and `vec_valid` are registered on the acknowledging edge and are compared during the one cycle after it. Mask and in-service changes from a write take effect at the write's edge, and `rdata` reflects them immediately after. A reference model in the bench advances at every rising edge and is compared at every falling edge while the cascaded pair is configured. Directed checks, placed one settling delay after a falling edge, cover single mode, level inputs and automatic end-of-interrupt.

// File: rtl/irqc_pkg.sv
// Shared constants, types and helpers for the interrupt controller.
// Assumes a byte-wide register interface and a power-of-two line count.
package irqc_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - IDX_W;

    // Bit positions in the first configuration word
    localparam int CW_START  = 4;
    localparam int CW_LEVEL  = 3;
    localparam int CW_SINGLE = 1;
    localparam int CW_MODE   = 0;
    // Bit position in the mode word
    localparam int MW_AUTO   = 1;

    typedef enum logic [1:0] {
        ST_READY,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE
    } init_st_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              level;
        logic              single;
        logic              aeoi;
        logic [LINES-1:0]  casc;
    } cfg_t;

    // Index of the lowest set bit (0 when none is set)
    function automatic logic [IDX_W-1:0] first_set(input logic [LINES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irqc_config.sv
// Register front end: walks the configuration word sequence, holds the
// configuration and the mask, and decodes the end-of-interrupt command.
// Assumes one write strobe per cycle at most.
module irqc_config
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [LINES-1:0]  mask,
    output logic              ready,
    output logic              init_pulse,
    output logic              eoi_pulse
);
    init_st_t state;
    logic     need_mode;

    // Command decode: start of configuration and non-specific end-of-interrupt
    always_comb begin
        init_pulse = wr_en && !reg_sel && wdata[CW_START];
        eoi_pulse  = wr_en && !reg_sel && ready && !wdata[CW_START]
                     && (wdata[7:5] == 3'b001) && !wdata[3];
    end

    assign ready = (state == ST_READY);

    // Sequence through the configuration words, then take mask writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_READY;
            need_mode  <= 1'b0;
            mask       <= '1;
            cfg.base   <= '0;
            cfg.level  <= 1'b0;
            cfg.single <= 1'b1;
            cfg.aeoi   <= 1'b0;
            cfg.casc   <= '0;
        end else if (init_pulse) begin
            state      <= ST_WAIT_BASE;
            cfg.level  <= wdata[CW_LEVEL];
            cfg.single <= wdata[CW_SINGLE];
            need_mode  <= wdata[CW_MODE];
            cfg.aeoi   <= 1'b0;
            mask       <= '0;
        end else if (wr_en && reg_sel) begin
            case (state)
                ST_WAIT_BASE: begin
                    cfg.base <= wdata[DATA_W-1:IDX_W];
                    if (!cfg.single)    state <= ST_WAIT_CASC;
                    else if (need_mode) state <= ST_WAIT_MODE;
                    else                state <= ST_READY;
                end
                ST_WAIT_CASC: begin
                    cfg.casc <= wdata;
                    state    <= need_mode ? ST_WAIT_MODE : ST_READY;
                end
                ST_WAIT_MODE: begin
                    cfg.aeoi <= wdata[MW_AUTO];
                    state    <= ST_READY;
                end
                default: mask <= wdata;
            endcase
        end
    end

    // R1: leaving the ready state needs a configuration-start command
    assert_init_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY && $past(state) == ST_READY)
        |-> $past(wr_en && !reg_sel && wdata[CW_START]));

    // R4: the mask only changes on a data write or a configuration start
    assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask != $past(mask)) |-> $past(wr_en));
endmodule

// File: rtl/irqc_requests.sv
// Request register: latches rising edges on edge lines until they are
// cleared by an acknowledge, and passes level lines straight through.
// Assumes the inputs are already synchronous to clk.
module irqc_requests
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] level_lines,
    input  logic [LINES-1:0] clr_onehot,
    input  logic             clr_all,
    output logic [LINES-1:0] irr
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] edge_q;

    // Remember last input sample and latch rising edges (set beats clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            edge_q <= '0;
        end else begin
            prev_q <= irq_in;
            edge_q <= ((edge_q & ~clr_onehot) | (irq_in & ~prev_q))
                      & ~{LINES{clr_all}};
        end
    end

    // Select the request source per line
    assign irr = (level_lines & irq_in) | (~level_lines & edge_q);

    // R8: a latched edge appears only after its input was seen high
    assert_edge_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_q & ~$past(edge_q)) & ~$past(irq_in)) == '0);
endmodule

// File: rtl/irqc_service.sv
// Priority resolver and in-service tracking: raises the interrupt,
// handles the acknowledge (local or cascaded) and end-of-interrupt.
// Assumes acknowledges are single-cycle pulses.
module irqc_service
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  cfg_t              cfg,
    input  logic              ready,
    input  logic [LINES-1:0]  irr,
    input  logic [LINES-1:0]  mask,
    input  logic              ack_in,
    input  logic [IDX_W-1:0]  cas_in,
    input  logic              eoi,
    input  logic              init,
    output logic              irq_out,
    output logic [LINES-1:0]  clr_onehot,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_strobe,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_valid
);
    logic [LINES-1:0] isr;
    logic [LINES-1:0] isr_next;
    logic [LINES-1:0] cand;
    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] s_idx;
    logic             outranks;
    logic             ack_eff;
    logic             take;

    // Find the winning request and compare it against the in-service set
    always_comb begin
        cand     = irr & ~mask;
        p_idx    = first_set(cand);
        s_idx    = first_set(isr);
        outranks = (|cand) && (!(|isr) || (p_idx < s_idx));
        irq_out  = ready && outranks;
    end

    // Decide whether this instance owns the acknowledge and where it goes
    always_comb begin
        ack_eff    = ready && ack_in
                     && (is_master || (cas_in == cfg.casc[IDX_W-1:0]));
        take       = ack_eff && outranks;
        cas_strobe = take && is_master && !cfg.single && cfg.casc[p_idx];
        cas_out    = p_idx;
        clr_onehot = take ? (LINES'(1) << p_idx) : '0;
    end

    // Next in-service set: end-of-interrupt, acknowledge, configuration clear
    always_comb begin
        isr_next = isr;
        if (eoi && (|isr))       isr_next[s_idx] = 1'b0;
        if (take && !cfg.aeoi)   isr_next[p_idx] = 1'b1;
        if (init)                isr_next = '0;
    end

    // Register the in-service set and the vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr       <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            isr       <= isr_next;
            vec_valid <= ack_eff && !cas_strobe;
            if (ack_eff) begin
                vec_out <= {cfg.base, (take ? p_idx : IDX_W'(LINES - 1))};
            end
        end
    end

    // R6: the in-service set grows only on an acknowledge
    assert_isr_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(isr) > $countones($past(isr))) |-> $past(ack_in));

    // R7: one end-of-interrupt retires at most one in-service bit
    assert_eoi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoi) && !$past(init)) |-> ($countones($past(isr)) <= $countones(isr) + 1));

    // R3: a vector is presented only after an acknowledge
    assert_vec_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_in));

    // R10: a cascade strobe comes only from a master that is interrupting
    assert_cascade_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cas_strobe |-> (is_master && irq_out));

    // R9: with automatic end-of-interrupt the in-service set never grows
    assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.aeoi && $past(cfg.aeoi)) |-> ($countones(isr) <= $countones($past(isr))));
endmodule

// File: rtl/irq_ctrl.sv
// Top of the cascadable interrupt controller: ties the register front end,
// the request register and the priority/service logic together.
// Assumes a master's cascade lines are driven by subordinate irq_out pins.
module irq_ctrl
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        is_master,
    input  logic        wr_en,
    input  logic        reg_sel,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  irq_in,
    output logic        irq_out,
    input  logic        ack_in,
    input  logic [2:0]  cas_in,
    output logic [2:0]  cas_out,
    output logic        cas_strobe,
    output logic [7:0]  vec_out,
    output logic        vec_valid
);
    cfg_t             cfg;
    logic [LINES-1:0] mask;
    logic [LINES-1:0] irr;
    logic [LINES-1:0] level_lines;
    logic [LINES-1:0] clr_onehot;
    logic             ready;
    logic             init_pulse;
    logic             eoi_pulse;

    irqc_config u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_sel    (reg_sel),
        .wdata      (wdata),
        .cfg        (cfg),
        .mask       (mask),
        .ready      (ready),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse)
    );

    // Level lines: all in level mode, else a master's cascade lines
    always_comb begin
        if (cfg.level)                    level_lines = {LINES{1'b1}};
        else if (is_master && !cfg.single) level_lines = cfg.casc;
        else                              level_lines = '0;
    end

    irqc_requests u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .level_lines (level_lines),
        .clr_onehot  (clr_onehot),
        .clr_all     (init_pulse),
        .irr         (irr)
    );

    irqc_service u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_master  (is_master),
        .cfg        (cfg),
        .ready      (ready),
        .irr        (irr),
        .mask       (mask),
        .ack_in     (ack_in),
        .cas_in     (cas_in),
        .eoi        (eoi_pulse),
        .init       (init_pulse),
        .irq_out    (irq_out),
        .clr_onehot (clr_onehot),
        .cas_out    (cas_out),
        .cas_strobe (cas_strobe),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid)
    );

    // Read path: mask on the data address, requests on the command address
    assign rdata = reg_sel ? mask : irr;

    // R1: no interrupt leaves the block while configuration is in progress
    assert_quiet_in_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_pulse) |-> !irq_out);
endmodule

// File: tb/sim_irq_ctrl.sv
// Bench: master u0 and subordinate u1 cascaded on master line 2,
// a behavioural reference model compared on every clock while tracking.
module sim_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_m = 1'b0, wr_s = 1'b0, sel = 1'b0, ack = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] mirq = 8'h00, sirq = 8'h00;
    logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
    logic       m_irq, s_irq, m_vv, s_vv, m_cstb, s_cstb;
    logic [2:0] m_cas, s_cas;
    int         checks = 0, fails = 0;
    bit         track = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .wr_en(wr_m), .reg_sel(sel),
        .wdata(wd), .rdata(m_rdata), .irq_in({mirq[7:3], s_irq, mirq[1:0]}),
        .irq_out(m_irq), .ack_in(ack), .cas_in(3'd0), .cas_out(m_cas),
        .cas_strobe(m_cstb), .vec_out(m_vec), .vec_valid(m_vv)
    );

    irq_ctrl u1 (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .wr_en(wr_s), .reg_sel(sel),
        .wdata(wd), .rdata(s_rdata), .irq_in(sirq), .irq_out(s_irq),
        .ack_in(m_cstb), .cas_in(m_cas), .cas_out(s_cas), .cas_strobe(s_cstb),
        .vec_out(s_vec), .vec_valid(s_vv)
    );

    wire [7:0] host_vec = m_vv ? m_vec : s_vec;
    wire       host_vv  = m_vv | s_vv;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model (cascade setup, edge, normal EOI) ----
    logic [7:0] m_mask = 8'hFF, s_mask = 8'hFF, m_isr = 0, s_isr = 0;
    logic [7:0] m_edge = 0, s_edge = 0, m_prev = 0, s_prev = 0;
    int         m_left = 0, s_left = 0;
    logic       exp_int = 0, exp_vv = 0;
    logic [7:0] exp_vec = 0;

    function automatic int low_bit(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic int s_top();
        int p;
        p = low_bit(s_edge & ~s_mask);
        if (s_left != 0) return -1;
        if (p < 8 && p < low_bit(s_isr)) return p;
        return -1;
    endfunction

    function automatic int m_top();
        logic [7:0] pend;
        int p;
        pend = m_edge;
        pend[2] = (s_top() >= 0);
        p = low_bit(pend & ~m_mask);
        if (m_left != 0) return -1;
        if (p < 8 && p < low_bit(m_isr)) return p;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 8'hFF; s_mask = 8'hFF; m_isr = 0; s_isr = 0;
            m_edge = 0; s_edge = 0; m_prev = 0; s_prev = 0;
            m_left = 0; s_left = 0; exp_vv = 0; exp_int = 0;
        end else begin
            int mr, sr;
            mr = m_top();
            sr = s_top();
            exp_vv = ack && (m_left == 0);
            if (exp_vv) begin
                if (mr == 2) begin
                    s_isr[sr] = 1'b1; s_edge[sr] = 1'b0; m_isr[2] = 1'b1;
                    exp_vec = 8'h28 + 8'(sr);
                end else if (mr >= 0) begin
                    m_isr[mr] = 1'b1; m_edge[mr] = 1'b0;
                    exp_vec = 8'h20 + 8'(mr);
                end else begin
                    exp_vec = 8'h27;
                end
            end
            m_edge = m_edge | (mirq & ~m_prev); m_edge[2] = 1'b0; m_prev = mirq;
            s_edge = s_edge | (sirq & ~s_prev); s_prev = sirq;
            if (wr_m) begin
                if (!sel && wd[4]) begin
                    m_left = 1 + (wd[1] ? 0 : 1) + (wd[0] ? 1 : 0);
                    m_mask = 0; m_isr = 0; m_edge = 0;
                end else if (sel) begin
                    if (m_left > 0) m_left--; else m_mask = wd;
                end else if (wd == 8'h20 && m_left == 0 && low_bit(m_isr) < 8) begin
                    m_isr[low_bit(m_isr)] = 1'b0;
                end
            end
            if (wr_s) begin
                if (!sel && wd[4]) begin
                    s_left = 1 + (wd[1] ? 0 : 1) + (wd[0] ? 1 : 0);
                    s_mask = 0; s_isr = 0; s_edge = 0;
                end else if (sel) begin
                    if (s_left > 0) s_left--; else s_mask = wd;
                end else if (wd == 8'h20 && s_left == 0 && low_bit(s_isr) < 8) begin
                    s_isr[low_bit(s_isr)] = 1'b0;
                end
            end
            exp_int = (m_top() >= 0);
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (track && rst_n && !done) begin
            chk("R5 host interrupt vs model", {7'd0, m_irq}, {7'd0, exp_int});
            chk("R3 vector strobe vs model", {7'd0, host_vv}, {7'd0, exp_vv});
            if (exp_vv) chk("R3 vector vs model", host_vec, exp_vec);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input bit slave, input bit s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wd = d;
        if (slave) wr_s = 1'b1; else wr_m = 1'b1;
        @(negedge clk);
        wr_s = 1'b0; wr_m = 1'b0;
        #1;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        #1;
    endtask

    task automatic line(input bit slave, input int idx, input bit v);
        @(negedge clk);
        if (slave) sirq[idx] = v; else mirq[idx] = v;
        @(negedge clk);
        #1;
    endtask

    task automatic peek(input bit slave, input bit s, output logic [7:0] v);
        sel = s; #1;
        v = slave ? s_rdata : m_rdata;
    endtask

    task automatic cascade_init();
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
        wr(0, 1, 8'h00); wr(1, 1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        peek(0, 1, v); chk("R2 reset mask", v, 8'hFF);
        chk("R2 reset irq_out", {7'd0, m_irq}, 8'h00);
        chk("R2 reset vec_valid", {7'd0, m_vv}, 8'h00);

        // R1/R2 configuration sequence with a request arriving mid-way
        wr(0, 0, 8'h11);
        peek(0, 1, v); chk("R2 mask cleared by first word", v, 8'h00);
        line(0, 5, 1);
        chk("R1 irq_out low during configuration", {7'd0, m_irq}, 8'h00);
        wr(0, 1, 8'h20); wr(0, 1, 8'h04);
        chk("R1 irq_out low before mode word", {7'd0, m_irq}, 8'h00);
        wr(0, 1, 8'h01);
        chk("R1 irq_out after configuration", {7'd0, m_irq}, 8'h01);
        line(0, 5, 0);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
        wr(0, 1, 8'h00); wr(1, 1, 8'h00);
        peek(1, 1, v); chk("R4 mask readback", v, 8'h00);
        track = 1'b1;

        // R3/R6 first acknowledge
        pulse_ack();
        chk("R3 vector line 5", host_vec, 8'h25);
        peek(0, 0, v); chk("R6 request cleared", v, 8'h00);
        chk("R6 in service blocks nothing pending", {7'd0, m_irq}, 8'h00);

        // R5/R7 priority and nesting
        @(negedge clk); mirq[6] = 1'b1; mirq[1] = 1'b1;
        @(negedge clk); #1;
        chk("R5 line1 outranks in-service 5", {7'd0, m_irq}, 8'h01);
        pulse_ack();
        chk("R5 highest priority wins", host_vec, 8'h21);
        chk("R5 line6 held back", {7'd0, m_irq}, 8'h00);
        wr(0, 0, 8'h20);
        chk("R7 EOI retires line1 only", {7'd0, m_irq}, 8'h00);
        wr(0, 0, 8'h20);
        chk("R7 EOI retires line5, line6 free", {7'd0, m_irq}, 8'h01);
        pulse_ack();
        chk("R5 vector line 6", host_vec, 8'h26);
        wr(0, 0, 8'h20);
        mirq = 8'h00;

        // R4 masking
        wr(0, 1, 8'h08);
        line(0, 3, 1);
        chk("R4 masked line silent", {7'd0, m_irq}, 8'h00);
        peek(0, 0, v); chk("R4 request still visible", v, 8'h08);
        wr(0, 1, 8'h00);
        chk("R4 unmasked line asserts", {7'd0, m_irq}, 8'h01);
        pulse_ack();
        chk("R4 vector line 3", host_vec, 8'h23);
        wr(0, 0, 8'h20);
        line(0, 3, 0);

        // R10 cascade acknowledge
        line(1, 4, 1);
        chk("R10 subordinate reaches host", {7'd0, m_irq}, 8'h01);
        pulse_ack();
        chk("R10 master gives no vector", {7'd0, m_vv}, 8'h00);
        chk("R10 subordinate gives vector", {7'd0, s_vv}, 8'h01);
        chk("R10 cascaded vector", host_vec, 8'h2C);
        wr(1, 0, 8'h20); wr(0, 0, 8'h20);
        line(1, 4, 0);

        // R11 masked cascade line
        wr(0, 1, 8'h04);
        line(1, 0, 1);
        chk("R11 subordinate interrupting", {7'd0, s_irq}, 8'h01);
        chk("R11 host sees nothing", {7'd0, m_irq}, 8'h00);
        wr(0, 1, 8'h00);
        chk("R11 unmask passes request", {7'd0, m_irq}, 8'h01);
        pulse_ack();
        chk("R11 vector line 8", host_vec, 8'h28);
        wr(1, 0, 8'h20); wr(0, 0, 8'h20);
        line(1, 0, 0);

        // R12 spurious acknowledge
        pulse_ack();
        chk("R12 spurious vector", host_vec, 8'h27);
        chk("R12 no in-service change", {7'd0, m_irq}, 8'h00);
        track = 1'b0;

        // R8 level mode (single, level, mode word)
        wr(0, 0, 8'h1B); wr(0, 1, 8'h40); wr(0, 1, 8'h01); wr(0, 1, 8'h00);
        line(0, 3, 1);
        peek(0, 0, v); chk("R8 level request visible", v, 8'h08);
        pulse_ack();
        chk("R8 level vector", host_vec, 8'h43);
        chk("R8 in service blocks", {7'd0, m_irq}, 8'h00);
        wr(0, 0, 8'h20);
        chk("R8 held level re-asserts", {7'd0, m_irq}, 8'h01);
        @(negedge clk); mirq[3] = 1'b0; #1;
        chk("R8 level follows pin", {7'd0, m_irq}, 8'h00);

        // R1 single mode without mode word: next data write is the mask
        wr(0, 0, 8'h12); wr(0, 1, 8'h40); wr(0, 1, 8'h5A);
        peek(0, 1, v); chk("R1 short sequence then mask", v, 8'h5A);

        // R9 automatic end-of-interrupt
        wr(0, 0, 8'h13); wr(0, 1, 8'h40); wr(0, 1, 8'h03); wr(0, 1, 8'h00);
        line(0, 4, 1);
        pulse_ack();
        chk("R9 vector line 4", host_vec, 8'h44);
        line(0, 6, 1);
        chk("R9 no in-service after ack", {7'd0, m_irq}, 8'h01);
        pulse_ack();
        chk("R9 vector line 6", host_vec, 8'h46);
        mirq = 8'h00;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule